// File: doc/BRIEF.md
# Two-Stage Sinc Decimation Filter

This block turns the one-bit output stream of a delta-sigma modulator into signed multi-bit samples. A fifth-order sinc stage with a fixed power-of-two ratio always runs first. A second sinc stage can follow it. This second stage has a selectable order and a selectable power-of-two ratio, and it further decimates the first-stage stream to give the low output rates. At the fastest setting the second stage is skipped, and results come straight from the fifth-order stage.

Each stage is built as a cascade of wrap-around integrators running at its input rate, followed by single-delay differentiators that run at its decimated rate. The result is scaled by a shift so that a full-scale input gives the same code in every mode. Whenever the rate or order code changes, the whole chain is cleared. Outputs are then withheld until the filter window holds only post-change data, and the valid strobe marks settled samples only.

Top module: `sinc2_decimator`

## Requirements
- R1: While `rst_n` is low and after reset, `result` is 0 and `result_valid` is low.
- R2: A modulator bit of 1 counts as +1 and a bit of 0 counts as -1. A constant stream of ones settles to +2^(OUT_W-2), which is +16384 at the defaults. A constant stream of zeros settles to -2^(OUT_W-2). This holds in every mode, and no settled result lies outside these two values.
- R3: Rate code 0 bypasses the second stage. One result appears for every 2^R1_LOG2 accepted bits, which is 8 at the defaults.
- R4: A rate code k >= 1 gives the second stage a ratio of 2^min(k, MAX_L2), so one result appears for every 2^R1_LOG2 * 2^min(k, MAX_L2) accepted bits. Codes above MAX_L2 (4 at the defaults) behave like MAX_L2.
- R5: Order codes 0, 1, 2 and 3 select second-stage orders 1, 3, 4 and 5. The result is shifted right by order*min(k, MAX_L2) extra bits, so the DC gain does not depend on the order or the rate.
- R6: A bit presented while `bit_en` is low is ignored and does not advance any counter.
- R7: A change of `rate_sel` or `order_sel` clears all filter state. The bit presented in that cycle is dropped. In bypass the first valid result follows the 6*2^R1_LOG2-th accepted bit. With the second stage, it comes one clock after the (5 + (N+1)*2^k)*2^R1_LOG2-th accepted bit, where N is the order.
- R8: `result_valid` is a single-cycle pulse, and `result` is meaningful while it is high.
- R9: Consider a periodic bit pattern whose period divides 2^R1_LOG2 and that has a fraction d of ones. Its settled result is (2d-1)*2^(OUT_W-2): three ones in four give +8192, one in four gives -8192 and one in two gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mod_bit | input | 1 | Modulator output bit |
| bit_en | input | 1 | Clock enable qualifying `mod_bit` |
| rate_sel | input | RATE_W | Rate code: 0 bypasses the second stage, k selects ratio 2^k |
| order_sel | input | 2 | Second-stage order code (1, 3, 4, 5) |
| result | output | OUT_W | Signed, normalized output sample |
| result_valid | output | 1 | One-cycle strobe per settled output sample |

## Verification
In bypass, a result is registered at the edge that takes the last bit of a first-stage period, so it is visible right after that edge. With the second stage there is one extra registered hop: the first-stage output register feeds the second stage, so the result appears one clock after the last bit. The bench drives its inputs on the falling edge and samples at the next falling edge. It counts accepted bits from the restart and compares the count at the first valid strobe with the R7 formula. The gaps between later strobes are checked against R3 and R4. For the bit_en test, only qualified bits are counted, so the due time is unchanged whatever the length of the stall.

// File: rtl/sincdec_pkg.sv
package sincdec_pkg;

   // Fixed order of the first stage; also the largest second-stage order.
   localparam int unsigned FIRST_ORDER = 5;

   // Order code of the second stage to its order (R5).
   function automatic logic [2:0] order_of(input logic [1:0] code);
      logic [2:0] n;
      case (code)
         2'd0:    n = 3'd1;
         2'd1:    n = 3'd3;
         2'd2:    n = 3'd4;
         default: n = 3'd5;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/sinc_integ.sv
// Cascade of wrap-around integrators. The next-value chain is combinational,
// so the registered sums add no latency to the window.
module sinc_integ #(
   parameter int W = 17,
   parameter int N = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                en,
   input  logic [W-1:0]        x,
   output logic [N-1:0][W-1:0] nxt
);
   logic [N-1:0][W-1:0] acc;

   assign nxt[0] = acc[0] + x;
   for (genvar k = 1; k < N; k++) begin : g_chain
      assign nxt[k] = acc[k] + nxt[k-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         acc <= '0;
      else if (en)
         acc <= nxt;
   end
endmodule

// File: rtl/sinc_comb.sv
// Cascade of single-delay differentiators that run at the decimated rate.
module sinc_comb #(
   parameter int W = 17,
   parameter int N = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                en,
   input  logic [W-1:0]        x,
   output logic [N-1:0][W-1:0] y
);
   logic [N-1:0][W-1:0] dly;

   assign y[0] = x - dly[0];
   for (genvar k = 1; k < N; k++) begin : g_diff
      assign y[k] = y[k-1] - dly[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         dly <= '0;
      else if (en) begin
         dly[0] <= x;
         for (int k = 1; k < N; k++)
            dly[k] <= y[k-1];
      end
   end
endmodule

// File: rtl/sinc_stage.sv
// One sinc stage: integrators, ratio counter, differentiators, order tap
// selection and settling suppression.
module sinc_stage #(
   parameter int W_IN = 2,
   parameter int W    = 17,
   parameter int NMAX = 5,
   parameter int LMAX = 3,
   localparam int RLW = $clog2(LMAX + 1),
   localparam int CW  = (LMAX > 0) ? LMAX : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            in_valid,
   input  logic [W_IN-1:0] x_in,
   input  logic [2:0]      ord,
   input  logic [RLW-1:0]  rlog,
   output logic [W-1:0]    y_out,
   output logic            y_valid
);
   if (W <= W_IN) begin : g_bad_width
      $error("sinc_stage: W must exceed W_IN");
   end
   if (NMAX < 1 || NMAX > 7) begin : g_bad_order
      $error("sinc_stage: NMAX out of range");
   end

   logic [W-1:0]           xs;
   logic [NMAX-1:0][W-1:0] nxt;
   logic [NMAX-1:0][W-1:0] dif;
   logic [W-1:0]           comb_in;
   logic [W-1:0]           comb_out;
   logic [CW-1:0]          cnt;
   logic [2:0]             settle;
   logic                   last;
   logic                   strobe;

   assign xs     = {{(W - W_IN){x_in[W_IN-1]}}, x_in};
   assign last   = (cnt == CW'((1 << rlog) - 1));
   assign strobe = in_valid && last && !clr;

   sinc_integ #(.W(W), .N(NMAX)) u_integ (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(in_valid), .x(xs), .nxt(nxt)
   );

   // Tap the chain at the selected order (R5).
   always_comb begin
      comb_in  = nxt[0];
      comb_out = dif[0];
      for (int k = 1; k < NMAX; k++) begin
         if (ord == 3'(k + 1)) begin
            comb_in  = nxt[k];
            comb_out = dif[k];
         end
      end
   end

   sinc_comb #(.W(W), .N(NMAX)) u_comb (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(strobe), .x(comb_in), .y(dif)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt     <= '0;
         settle  <= '0;
         y_valid <= 1'b0;
      end else begin
         y_valid <= 1'b0;
         if (in_valid)
            cnt <= last ? '0 : cnt + 1'b1;
         if (strobe) begin
            if (settle == ord)
               y_valid <= 1'b1;
            else
               settle <= settle + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         y_out <= '0;
      else if (strobe && settle == ord)
         y_out <= comb_out;
   end

   // R6: an output only follows an accepted input sample.
   assert_out_needs_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid |-> $past(in_valid));
   // R7: a clear silences the stage on the following cycle.
   assert_clear_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !y_valid);
endmodule

// File: rtl/sinc2_decimator.sv
module sinc2_decimator
   import sincdec_pkg::*;
#(
   parameter int R1_LOG2 = 3,
   parameter int MAX_L2  = 4,
   parameter int RATE_W  = 3,
   parameter int OUT_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_bit,
   input  logic              bit_en,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic [1:0]        order_sel,
   output logic [OUT_W-1:0]  result,
   output logic              result_valid
);
   localparam int N1   = FIRST_ORDER;
   localparam int W1   = N1 * R1_LOG2 + 2;
   localparam int W2   = W1 + FIRST_ORDER * MAX_L2;
   localparam int SH1  = N1 * R1_LOG2 - (OUT_W - 2);
   localparam int R1   = 1 << R1_LOG2;
   localparam int RLW1 = $clog2(R1_LOG2 + 1);
   localparam int RLW2 = $clog2(MAX_L2 + 1);
   localparam int FS   = 1 << (OUT_W - 2);

   if (R1_LOG2 < 1) begin : g_bad_r1
      $error("sinc2_decimator: first-stage ratio must be at least 2");
   end
   if (MAX_L2 < 1) begin : g_bad_l2
      $error("sinc2_decimator: MAX_L2 must be at least 1");
   end
   if (SH1 < 0) begin : g_bad_out
      $error("sinc2_decimator: OUT_W too wide for first-stage growth");
   end
   if ((1 << RATE_W) <= MAX_L2) begin : g_bad_rate
      $error("sinc2_decimator: RATE_W cannot reach MAX_L2");
   end

   logic [RATE_W-1:0] rate_q;
   logic [1:0]        order_q;
   logic              chg;
   logic              bypass;
   logic [RLW2-1:0]   rlog2;
   logic [2:0]        ord_n;
   logic [5:0]        sh2;
   logic [1:0]        x1;
   logic [W1-1:0]     s1_y;
   logic              s1_valid;
   logic [W2-1:0]     s2_y;
   logic              s2_valid;

   // R7: any change of a select code restarts the chain.
   assign chg = (rate_sel != rate_q) || (order_sel != order_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q  <= '0;
         order_q <= '0;
      end else if (chg) begin
         rate_q  <= rate_sel;
         order_q <= order_sel;
      end
   end

   assign bypass = (rate_q == '0);
   assign rlog2  = (int'(rate_q) > MAX_L2) ? RLW2'(MAX_L2) : RLW2'(rate_q);
   assign ord_n  = order_of(order_q);
   assign sh2    = 6'(int'(ord_n) * int'(rlog2) + SH1);
   assign x1     = mod_bit ? 2'b01 : 2'b11;   // R2: +1 / -1

   sinc_stage #(.W_IN(2), .W(W1), .NMAX(N1), .LMAX(R1_LOG2)) u_stage1 (
      .clk(clk), .rst_n(rst_n), .clr(chg), .in_valid(bit_en), .x_in(x1),
      .ord(3'(N1)), .rlog(RLW1'(R1_LOG2)), .y_out(s1_y), .y_valid(s1_valid)
   );

   sinc_stage #(.W_IN(W1), .W(W2), .NMAX(FIRST_ORDER), .LMAX(MAX_L2)) u_stage2 (
      .clk(clk), .rst_n(rst_n), .clr(chg), .in_valid(s1_valid && !bypass),
      .x_in(s1_y), .ord(ord_n), .rlog(rlog2), .y_out(s2_y), .y_valid(s2_valid)
   );

   // Gain normalization by arithmetic shift, truncated to OUT_W (R5).
   assign result       = bypass ? OUT_W'($signed(s1_y) >>> SH1)
                                : OUT_W'($signed(s2_y) >>> sh2);
   assign result_valid = bypass ? s1_valid : s2_valid;

   logic [15:0] gap;
   logic        seen;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (result_valid) begin
         gap  <= '0;
         seen <= 1'b1;
      end else if (gap != 16'hFFFF) begin
         gap <= gap + 1'b1;
      end
   end

   assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);
   assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> !result_valid);
   assert_result_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> ($signed(result) <= FS && $signed(result) >= -FS));
   assert_min_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && seen) |-> (int'(gap) >= R1 - 1));
endmodule

// File: tb/tb_sinc2_decimator.sv
module tb_sinc2_decimator;
   localparam int CLK_PERIOD = 10;
   localparam int R1_LOG2 = 3;
   localparam int MAX_L2  = 4;
   localparam int OUT_W   = 16;
   localparam int R1      = 1 << R1_LOG2;
   localparam int FS      = 1 << (OUT_W - 2);
   localparam int WATCHDOG = 150000;

   // {rate[2:0], order[1:0], pattern[3:0], expected[15:0]}
   localparam int NV = 9;
   localparam logic [24:0] VEC [NV] = '{
      {3'd0, 2'd0, 4'b1111, 16'sd16384},
      {3'd0, 2'd2, 4'b0000, -16'sd16384},
      {3'd0, 2'd1, 4'b1010, 16'sd0},
      {3'd1, 2'd0, 4'b1110, 16'sd8192},
      {3'd2, 2'd1, 4'b1000, -16'sd8192},
      {3'd3, 2'd2, 4'b1111, 16'sd16384},
      {3'd4, 2'd3, 4'b0000, -16'sd16384},
      {3'd7, 2'd3, 4'b1100, 16'sd0},
      {3'd2, 2'd3, 4'b1110, 16'sd8192}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mod_bit = 1'b0;
   logic              bit_en = 1'b0;
   logic [2:0]        rate_sel = '0;
   logic [1:0]        order_sel = '0;
   logic [OUT_W-1:0]  result;
   logic              result_valid;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int phase  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sinc2_decimator #(.R1_LOG2(R1_LOG2), .MAX_L2(MAX_L2), .RATE_W(3), .OUT_W(OUT_W)) dut (
      .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .bit_en(bit_en),
      .rate_sel(rate_sel), .order_sel(order_sel),
      .result(result), .result_valid(result_valid)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == WATCHDOG) begin
         fails  = fails + 1;
         checks = checks + 1;
         $display("FAIL watchdog (all requirements): cycles=%0d expected below %0d", cycles, WATCHDOG);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input logic b, input logic c);
      mod_bit = b;
      bit_en  = c;
      @(posedge clk);
      @(negedge clk);
   endtask

   // Two select changes in a row guarantee a restart (R7).
   task automatic restart(input logic [2:0] r, input logic [1:0] o);
      rate_sel  = r;
      order_sel = o ^ 2'd1;
      tick(1'b0, 1'b0);
      order_sel = o;
      tick(1'b0, 1'b0);
      phase = 0;
   endtask

   task automatic wait_valid(input logic [3:0] pat, input int limit,
                             output int ticks, output int val);
      ticks = 0;
      val   = 0;
      while (ticks < limit) begin
         tick(pat[phase[1:0]], 1'b1);
         phase++;
         ticks++;
         if (result_valid) begin
            val = int'($signed(result));
            return;
         end
      end
      ticks = -1;
   endtask

   initial begin
      @(negedge clk);
      tick(1'b0, 1'b0);
      // R1: reset state
      chk(result == '0, "R1 result in reset", int'(result), 0);
      chk(result_valid == 1'b0, "R1 valid in reset", int'(result_valid), 0);
      rst_n = 1'b1;
      tick(1'b0, 1'b0);
      chk(result == '0 && !result_valid, "R1 after release", int'(result), 0);

      for (int v = 0; v < NV; v++) begin
         logic [2:0] r;
         logic [1:0] o;
         logic [3:0] p;
         int exp, n, l2, first, space, t, val;
         string rq;
         {r, o, p} = VEC[v][24:16];
         exp   = int'($signed(VEC[v][15:0]));
         n     = (o == 2'd0) ? 1 : int'(o) + 2;
         l2    = (int'(r) > MAX_L2) ? MAX_L2 : int'(r);
         first = (r == 0) ? 6 * R1 : R1 * (5 + (n + 1) * (1 << l2)) + 1;
         space = (r == 0) ? R1 : R1 << l2;
         rq    = (r == 0) ? "R3" : "R4";
         restart(r, o);
         wait_valid(p, 4000, t, val);
         chk(t == first, "R7 first valid bit count", t, first);
         chk(val == exp, "R2/R9/R5 first settled value", val, exp);
         tick(p[phase[1:0]], 1'b1);
         phase++;
         chk(!result_valid, "R8 single-cycle valid", int'(result_valid), 0);
         wait_valid(p, 4000, t, val);
         chk(t + 1 == space, {rq, " output spacing"}, t + 1, space);
         chk(val == exp, "R2/R9/R5 second value", val, exp);
      end

      // R6: qualify only every other bit; disabled bits are opposite polarity.
      begin
         int bits;
         bit early;
         restart(3'd0, 2'd0);
         bits  = 0;
         early = 0;
         while (bits < 200 && !result_valid) begin
            tick(1'b1, 1'b1);
            bits++;
            if (!result_valid) begin
               tick(1'b0, 1'b0);
               if (result_valid) early = 1;
            end
         end
         chk(!early, "R6 no output on disabled cycle", int'(early), 0);
         chk(bits == 6 * R1, "R6 accepted bit count", bits, 6 * R1);
         chk(int'($signed(result)) == FS, "R6 disabled bits ignored", int'($signed(result)), FS);
      end

      // R7: change mid-stream; nothing valid until the window refills.
      begin
         int t, val;
         order_sel = 2'd3;
         tick(1'b1, 1'b1);
         chk(!result_valid, "R7 quiet after change", int'(result_valid), 0);
         phase = 0;
         wait_valid(4'b1111, 1000, t, val);
         chk(t == 6 * R1, "R7 restart delay", t, 6 * R1);
      end

      // R1: reset during operation
      rst_n = 1'b0;
      tick(1'b1, 1'b1);
      chk(result == '0, "R1 result after mid-run reset", int'(result), 0);
      chk(!result_valid, "R1 valid after mid-run reset", int'(result_valid), 0);
      rst_n = 1'b1;
      tick(1'b0, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule